// File: doc/BRIEF.md
# Configurable Input-Pattern Reset Generator

This block watches a small group of input pins and raises a system reset when a programmable pattern appears on them. Each pin is resynchronized by a two-flop chain. It then passes through a four-way term selector that yields constant 0, the pin, the inverted pin, or constant 1. The per-pin terms are merged by a wide AND or a wide OR, chosen by a mode bit. The merged result is the reset condition.

While the chip is awake (active or standby), the condition must stay true for a debounce window of `DEBOUNCE_CYCLES` consecutive clocks before reset is raised. At 32 kHz this window is 512 cycles. When the chip is asleep and the sleep-bypass bit is set, a true condition raises reset on the next clock with no debounce. Once raised, reset follows the condition and falls one clock after the condition goes false.

Configuration is written through a small write-only stream port (`cfg_valid`/`cfg_ready`). `cfg_ready` is always high, so the port never applies back-pressure. A beat transfers on every clock where `cfg_valid` is high. Reads are not provided.

Top module: `pinpat_reset_gen`

## Requirements
- R1: After `rst_n` is released, `reset_o` is 0, every selector is 00, the combine mode is AND and sleep bypass is off. With these defaults, no pin pattern raises `reset_o`.
- R2: Pin n's 2-bit selector is {high bit from address 0 bit n, low bit from address 1 bit n}. The codes are: 00 gives constant 0, 01 gives the synchronized pin, 10 gives the inverted synchronized pin, 11 gives constant 1.
- R3: With control bit 0 = 0 (AND mode), the condition is the AND of all terms. A term at 00 blocks reset. With all selectors at 11, reset is raised whatever the pins are.
- R4: With control bit 0 = 1 (OR mode), the condition is the OR of all terms, and a term at 00 is a don't-care.
- R5: When not bypassed, `reset_o` rises after the clock edge at which the condition has been sampled true on `DEBOUNCE_CYCLES` consecutive edges, and not earlier.
- R6: If the condition is sampled false before the count completes, the debounce count starts again from zero.
- R7: With `sleep_i` = 1 and control bit 1 = 1 (sleep bypass), `reset_o` rises one clock after the synchronized condition becomes true.
- R8: The debounce still applies when `sleep_i` = 1 with bypass off, and when bypass is on while `sleep_i` = 0.
- R9: `reset_o` stays high while the condition stays true, and falls one clock after the condition is sampled false.
- R10: A pin change reaches the condition after two clock edges through a two-flop synchronizer.
- R11: `cfg_ready` is always 1. Addresses 0, 1 and 2 (control) are written when `cfg_valid` is high, and writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration write beat valid |
| cfg_ready | output | 1 | Always 1; the port accepts every beat |
| cfg_addr | input | 2 | 0: selector high bits, 1: selector low bits, 2: control |
| cfg_wdata | input | NUM_PINS | Write data; control uses bit 0 (OR mode) and bit 1 (sleep bypass) |
| pins_i | input | NUM_PINS | Asynchronous pattern pins |
| sleep_i | input | 1 | Chip is in sleep mode |
| reset_o | output | 1 | Generated system reset, active high |

## Verification
Two events can fall in the same cycle: the debounce count can be about to complete just as the condition drops for one cycle. The bench provokes this with a one-cycle glitch on the pins a few counts into the window. The expected rise is then placed exactly `DEBOUNCE_CYCLES` edges after the glitch, not after the first edge. A second overlap arises when a configuration write changes the condition while a count is in flight. The exhaustive sweep over selectors, pins and both modes lets those writes land mid-count, and judges only the settled `reset_o` against the arithmetic pattern.

// File: rtl/pinpat_pkg.sv
package pinpat_pkg;
  typedef enum logic [1:0] {
    TERM_ZERO = 2'b00,
    TERM_PIN  = 2'b01,
    TERM_INV  = 2'b10,
    TERM_ONE  = 2'b11
  } term_sel_e;

  localparam logic [1:0] ADDR_SEL_HI = 2'd0;
  localparam logic [1:0] ADDR_SEL_LO = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_OR_BIT     = 0;
  localparam int CTRL_BYPASS_BIT = 1;
endpackage

// File: rtl/pinpat_cfg.sv
module pinpat_cfg
  import pinpat_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [NUM_PINS-1:0] wr_data,
  output logic [NUM_PINS-1:0] sel_hi,
  output logic [NUM_PINS-1:0] sel_lo,
  output logic                or_mode,
  output logic                bypass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi  <= '0;
      sel_lo  <= '0;
      or_mode <= 1'b0;
      bypass  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_SEL_HI: sel_hi <= wr_data;
        ADDR_SEL_LO: sel_lo <= wr_data;
        ADDR_CTRL: begin
          or_mode <= wr_data[CTRL_OR_BIT];
          bypass  <= wr_data[CTRL_BYPASS_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pinpat_sync.sv
module pinpat_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinpat_combine.sv
module pinpat_combine
  import pinpat_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0] pins,
  input  logic [NUM_PINS-1:0] sel_hi,
  input  logic [NUM_PINS-1:0] sel_lo,
  input  logic                or_mode,
  output logic                cond
);
  logic [NUM_PINS-1:0] term;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_term
    term_sel_e code;
    assign code = term_sel_e'({sel_hi[n], sel_lo[n]});
    always_comb begin
      case (code)
        TERM_ZERO: term[n] = 1'b0;
        TERM_PIN:  term[n] = pins[n];
        TERM_INV:  term[n] = ~pins[n];
        default:   term[n] = 1'b1;
      endcase
    end
  end

  assign cond = or_mode ? (|term) : (&term);
endmodule

// File: rtl/pinpat_debounce.sv
module pinpat_debounce #(
  parameter int DEBOUNCE_CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic skip,
  output logic rst_out
);
  localparam int CNT_W = (DEBOUNCE_CYCLES > 2) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!cond)   cnt_q <= '0;
    else if (!at_last) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_out <= 1'b0;
    else        rst_out <= cond & (at_last | rst_out | skip);
  end
endmodule

// File: rtl/pinpat_reset_gen.sv
module pinpat_reset_gen #(
  parameter int NUM_PINS        = 4,
  parameter int DEBOUNCE_CYCLES = 512,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [1:0]          cfg_addr,
  input  logic [NUM_PINS-1:0] cfg_wdata,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                sleep_i,
  output logic                reset_o
);
  logic [NUM_PINS-1:0] sel_hi, sel_lo, pins_s;
  logic                or_mode, bypass, cond;

  assign cfg_ready = 1'b1;

  pinpat_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_valid & cfg_ready),
    .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .sel_hi(sel_hi), .sel_lo(sel_lo), .or_mode(or_mode), .bypass(bypass)
  );

  pinpat_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_i), .q(pins_s)
  );

  pinpat_combine #(.NUM_PINS(NUM_PINS)) u_comb (
    .pins(pins_s), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .or_mode(or_mode), .cond(cond)
  );

  pinpat_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .cond(cond),
    .skip(sleep_i & bypass), .rst_out(reset_o)
  );
endmodule

// File: rtl/pinpat_reset_chk.sv
module pinpat_reset_chk #(
  parameter int N   = 4,
  parameter int DEB = 512
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sleep_i,
  input logic         reset_o,
  input logic         cond,
  input logic         or_mode,
  input logic         bypass,
  input logic [N-1:0] sel_hi,
  input logic [N-1:0] sel_lo
);
  localparam int RW = $clog2(DEB + 1);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_q <= '0;
    else if (!cond)             run_q <= '0;
    else if (run_q != RW'(DEB)) run_q <= run_q + 1'b1;
  end

  assert_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!or_mode && (&sel_hi) && (&sel_lo)) |-> cond);

  assert_or_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (or_mode && sel_hi == '0 && sel_lo == '0) |-> !cond);

  assert_debounce_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reset_o) && !$past(sleep_i && bypass)) |-> ($past(run_q) >= RW'(DEB - 1)));

  assert_sleep_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && bypass && cond) |=> reset_o);

  assert_drop_one_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_o && !cond) |=> !reset_o);

  assert_rise_needs_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_o) |-> $past(cond));
endmodule

bind pinpat_reset_gen pinpat_reset_chk #(.N(NUM_PINS), .DEB(DEBOUNCE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .reset_o(reset_o), .cond(cond),
  .or_mode(or_mode), .bypass(bypass), .sel_hi(sel_hi), .sel_lo(sel_lo)
);

// File: tb/pinpat_reset_gen_tb.sv
module pinpat_reset_gen_tb_top;
  localparam int NP  = 4;
  localparam int DEB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [1:0]    cfg_addr = '0;
  logic [NP-1:0] cfg_wdata = '0;
  logic [NP-1:0] pins_i = '0;
  logic          sleep_i = 1'b0;
  logic          reset_o;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinpat_reset_gen #(.NUM_PINS(NP), .DEBOUNCE_CYCLES(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pins_i(pins_i),
    .sleep_i(sleep_i), .reset_o(reset_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
    cfg_valid = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    tick(1);
    cfg_valid = 1'b0;
  endtask

  function automatic logic exp_cond(input logic [NP-1:0] hi, input logic [NP-1:0] lo,
                                    input logic [NP-1:0] p, input logic orm);
    logic [NP-1:0] t;
    for (int n = 0; n < NP; n++) begin
      case ({hi[n], lo[n]})
        2'b00:   t[n] = 1'b0;
        2'b01:   t[n] = p[n];
        2'b10:   t[n] = ~p[n];
        default: t[n] = 1'b1;
      endcase
    end
    return orm ? |t : &t;
  endfunction

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          checks++;
          errs++;
          $display("FAIL watchdog: got hung expected finish");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
          $finish;
        end
      end
    join_none
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state and defaults block any pattern
    check(reset_o, 1'b0, "R1 reset_o after reset");
    check(cfg_ready, 1'b1, "R11 cfg_ready high");
    pins_i = '1;
    tick(DEB + 4);
    check(reset_o, 1'b0, "R1 default selectors block reset");
    pins_i = '0;
    tick(3);

    // R11: address 3 writes ignored
    wr(2'd3, '1);
    pins_i = '1;
    tick(DEB + 4);
    check(reset_o, 1'b0, "R11 address 3 ignored");
    pins_i = '0;

    // R3: all selectors 11 in AND mode resets regardless of pins
    wr(2'd0, '1);
    wr(2'd1, '1);
    tick(DEB + 1);
    check(reset_o, 1'b1, "R3 all-ones permanent reset");
    pins_i = 4'b1010;
    tick(4);
    check(reset_o, 1'b1, "R3 all-ones ignores pins");

    // R2/R3/R4: exhaustive sweep over mode, selectors and pins
    for (int m = 0; m < 2; m++) begin
      wr(2'd2, NP'(m));
      for (int s = 0; s < 256; s++) begin
        wr(2'd0, NP'(s >> 4));
        wr(2'd1, NP'(s & 15));
        for (int p = 0; p < 16; p++) begin
          pins_i = NP'(p);
          tick(2 + DEB + 1);
          check(reset_o, exp_cond(NP'(s >> 4), NP'(s & 15), NP'(p), m[0]),
                m[0] ? "R4 OR sweep (R2 codes)" : "R3 AND sweep (R2 codes)");
        end
      end
    end

    // Direct pins in AND mode for timing checks
    wr(2'd2, '0);
    wr(2'd0, '0);
    wr(2'd1, '1);
    pins_i = '0;
    tick(4);

    // R5/R10: debounce boundary counted from the pin edge
    pins_i = '1;
    tick(1 + DEB);
    check(reset_o, 1'b0, "R5 no reset one edge early");
    tick(1);
    check(reset_o, 1'b1, "R5 reset after full window");
    tick(5);
    check(reset_o, 1'b1, "R9 held while condition true");
    pins_i = '0;
    tick(2);
    check(reset_o, 1'b1, "R10 synchronizer delay before drop");
    tick(1);
    check(reset_o, 1'b0, "R9 drop one clock after false");
    tick(3);

    // R6: one-cycle glitch restarts the count
    pins_i = '1;
    tick(DEB - 3);
    pins_i = '0;
    tick(1);
    pins_i = '1;
    tick(DEB + 1);
    check(reset_o, 1'b0, "R6 count restarted after glitch");
    tick(1);
    check(reset_o, 1'b1, "R6 reset after restarted window");
    pins_i = '0;
    tick(4);

    // R7: sleep bypass
    wr(2'd2, NP'(2));
    sleep_i = 1'b1;
    tick(2);
    pins_i = '1;
    tick(2);
    check(reset_o, 1'b0, "R7 before synchronized condition");
    tick(1);
    check(reset_o, 1'b1, "R7 immediate reset in sleep bypass");
    pins_i = '0;
    tick(3);
    check(reset_o, 1'b0, "R7 release after sleep bypass");

    // R8: debounce with sleep but no bypass, and bypass while awake
    for (int k = 0; k < 2; k++) begin
      if (k == 0) begin
        wr(2'd2, '0);
        sleep_i = 1'b1;
      end else begin
        wr(2'd2, NP'(2));
        sleep_i = 1'b0;
      end
      tick(3);
      pins_i = '1;
      tick(3);
      check(reset_o, 1'b0, "R8 no early reset");
      tick(DEB - 2);
      check(reset_o, 1'b0, "R8 no reset one edge early");
      tick(1);
      check(reset_o, 1'b1, "R8 reset after debounce");
      pins_i = '0;
      tick(4);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule